// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block drives a parameterised set of active-low chip-select lines on behalf of an SPI host. Software writes four word registers over the host controller's word-write port: a line index, an idle-level mask, a mode and a delay register. The index picks the one line that hardware may assert. The mask gives every line its inactive level. The mode decides whether the picked line follows serial frames automatically, stays asserted, or is left alone. Any write whose value lies outside the legal range for its register is dropped without effect.

The serial engine supplies three single-cycle strobes: a frame request, an end-of-frame marker and a tick for every SCK half-period. In automatic mode the controller asserts the chosen line on a frame request. It then counts a programmable number of half-period ticks before it tells the engine, through a one-cycle go pulse, that it may start clocking. After the end-of-frame marker it waits a second programmable number of ticks before it releases the line. In the other modes the go pulse follows the request after one cycle, with no wait.

Register map (word address on `wrAddr`): 0 = line index, 1 = idle-level mask, 2 = mode, 3 = delays. The line outputs are driven from registered state through a mux only, so a change shows on the edge at which the write or strobe is sampled.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After reset, all N lines are high, the mask is all ones for the N implemented lines only, the index is 0, the mode is automatic (0), both delays are 1, and `leadDone` is low.
- R2: A write to address 0 with a value of N or more is dropped and the old index is kept. A smaller value becomes the new index, and the outputs follow it on the same edge.
- R3: A write to address 1 with a value of 2^N or more is dropped. An accepted mask sets the inactive level of each line, bit i for line i.
- R4: A write to address 2 with a value above 3 is dropped and the previous mode stays in force.
- R5: In hold mode (2), the indexed line is driven to the inverse of its mask bit and every other line sits at its mask bit, whatever the frame strobes do.
- R6: In modes 1 and 3, every line sits at its mask bit, and frame strobes never move any line.
- R7: In automatic mode (0), the indexed line takes the inverse of its mask bit from the edge that samples `frameStart` until its release. All other lines stay at their mask bits.
- R8: The lead count is held in bits 7:0 of address 3. In automatic mode, `leadDone` pulses for one cycle after the lead-th `halfTick` that follows `frameStart`. If the lead count is 0, or the mode is not automatic, `leadDone` pulses in the cycle right after `frameStart`.
- R9: The trail count is held in bits 23:16 of address 3. In automatic mode, the line is released on the edge that samples the trail-th `halfTick` after `frameEnd`. It is released on the edge that samples `frameEnd` when the trail count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register word address |
| wrData | input | 32 | Register write data |
| frameStart | input | 1 | Serial engine requests a frame |
| frameEnd | input | 1 | Serial engine has made the last SCK edge of the frame |
| halfTick | input | 1 | One pulse per SCK half-period |
| leadDone | output | 1 | Pulse: the engine may start clocking |
| csN | output | N | Chip-select lines, active low |

## Verification
Random register writes mix legal values with values just past each limit: index N, mask 2^N, mode 4. A controller that checked the wrong bound would move a line that should have held still. Directed frames run with lead and trail counts of 0, 1 and several ticks, so an off-by-one counter shifts the go pulse or the release by one tick and is caught. Masks with zero bits cover active-high idle lines, where a design that always drove the chosen line low would show the wrong level. Frames in modes 1 and 3, and an index change while in hold mode, cover recomputation and the cases where hardware must leave the lines alone.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

  localparam int REG_ADDR_W = 2;
  localparam int DLY_W      = 8;

  localparam logic [REG_ADDR_W-1:0] ADDR_SEL  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_DLY  = 2'd3;

  // bit fields inside the delay word
  localparam int LEAD_LSB  = 0;
  localparam int TRAIL_LSB = 16;

  typedef enum logic [1:0] {
    MODE_AUTO = 2'd0,
    MODE_RSVD = 2'd1,
    MODE_HOLD = 2'd2,
    MODE_OFF  = 2'd3
  } csMode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_BUSY,
    SEQ_TRAIL
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic autoLine;  // automatic sequence owns the line
    logic holdLine;  // line is held by software mode
  } csStrobe_t;

endpackage

// File: rtl/spi_cs_datapath.sv
module spi_cs_datapath
  import spi_cs_pkg::*;
#(
  parameter int N     = 1,
  parameter int SEL_W = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [31:0]           wrData,
  input  csStrobe_t             strobe,
  output logic [SEL_W-1:0]      selIdx,
  output logic [N-1:0]          maskQ,
  output csMode_e               modeQ,
  output logic [DLY_W-1:0]      leadCnt,
  output logic [DLY_W-1:0]      trailCnt,
  output logic [N-1:0]          csN
);

  localparam logic [31:0] SEL_LIMIT = 32'(N);

  logic selOk;
  logic maskOk;
  logic modeOk;

  // range checks on the incoming word
  assign selOk  = wrData < SEL_LIMIT;
  assign maskOk = (wrData >> N) == 32'd0;
  assign modeOk = wrData[31:2] == 30'd0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx   <= '0;
      maskQ    <= '1;
      modeQ    <= MODE_AUTO;
      leadCnt  <= DLY_W'(1);
      trailCnt <= DLY_W'(1);
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_SEL:  if (selOk)  selIdx <= wrData[SEL_W-1:0];
        ADDR_MASK: if (maskOk) maskQ  <= wrData[N-1:0];
        ADDR_MODE: if (modeOk) modeQ  <= csMode_e'(wrData[1:0]);
        ADDR_DLY: begin
          leadCnt  <= wrData[LEAD_LSB +: DLY_W];
          trailCnt <= wrData[TRAIL_LSB +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  logic lineOn;
  assign lineOn = strobe.autoLine | strobe.holdLine;

  // one output slice per line: flip the idle level when chosen and active
  for (genvar i = 0; i < N; i++) begin : g_line
    logic chosen;
    assign chosen = (32'(selIdx) == 32'(i));
    assign csN[i] = (lineOn && chosen) ? ~maskQ[i] : maskQ[i];
  end

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csMode_e          modeQ,
  input  logic [DLY_W-1:0] leadCnt,
  input  logic [DLY_W-1:0] trailCnt,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             halfTick,
  output csStrobe_t        strobe,
  output logic             leadDone
);

  seqState_e       state;
  seqState_e       stateNext;
  logic [DLY_W:0]  cnt;
  logic [DLY_W:0]  cntNext;
  logic [DLY_W:0]  cntInc;
  logic            goNext;
  logic            autoMode;
  logic            leadReached;
  logic            trailReached;

  assign autoMode     = (modeQ == MODE_AUTO);
  assign cntInc       = cnt + 1'b1;
  assign leadReached  = cntInc >= {1'b0, leadCnt};
  assign trailReached = cntInc >= {1'b0, trailCnt};

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    goNext    = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (frameStart) begin
          if (!autoMode || leadCnt == '0) begin
            goNext    = 1'b1;
            stateNext = autoMode ? SEQ_BUSY : SEQ_IDLE;
          end else begin
            stateNext = SEQ_LEAD;
            cntNext   = '0;
          end
        end
      end
      SEQ_LEAD: begin
        if (halfTick) begin
          if (leadReached) begin
            goNext    = 1'b1;
            stateNext = SEQ_BUSY;
          end else begin
            cntNext = cntInc;
          end
        end
      end
      SEQ_BUSY: begin
        if (frameEnd) begin
          if (trailCnt == '0) begin
            stateNext = SEQ_IDLE;
          end else begin
            stateNext = SEQ_TRAIL;
            cntNext   = '0;
          end
        end
      end
      SEQ_TRAIL: begin
        if (halfTick) begin
          if (trailReached) stateNext = SEQ_IDLE;
          else              cntNext   = cntInc;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      cnt      <= '0;
      leadDone <= 1'b0;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      leadDone <= goNext;
    end
  end

  assign strobe.autoLine = autoMode && (state != SEQ_IDLE);
  assign strobe.holdLine = (modeQ == MODE_HOLD);

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int N = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [31:0]           wrData,
  input  logic                  frameStart,
  input  logic                  frameEnd,
  input  logic                  halfTick,
  output logic                  leadDone,
  output logic [N-1:0]          csN
);

  localparam int SEL_W = (N > 1) ? $clog2(N) : 1;

  csStrobe_t        strobe;
  logic [SEL_W-1:0] selIdx;
  logic [N-1:0]     maskQ;
  csMode_e          modeQ;
  logic [DLY_W-1:0] leadCnt;
  logic [DLY_W-1:0] trailCnt;

  spi_cs_datapath #(.N(N), .SEL_W(SEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .selIdx   (selIdx),
    .maskQ    (maskQ),
    .modeQ    (modeQ),
    .leadCnt  (leadCnt),
    .trailCnt (trailCnt),
    .csN      (csN)
  );

  spi_cs_sequencer u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .modeQ      (modeQ),
    .leadCnt    (leadCnt),
    .trailCnt   (trailCnt),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .halfTick   (halfTick),
    .strobe     (strobe),
    .leadDone   (leadDone)
  );

endmodule

// File: rtl/spi_cs_checker.sv
module spi_cs_checker
  import spi_cs_pkg::*;
#(
  parameter int N     = 1,
  parameter int SEL_W = 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [REG_ADDR_W-1:0] wrAddr,
  input logic [31:0]           wrData,
  input logic                  frameStart,
  input logic                  halfTick,
  input logic                  leadDone,
  input logic [N-1:0]          csN,
  input logic [SEL_W-1:0]      selIdx,
  input logic [N-1:0]          maskQ,
  input csMode_e               modeQ
);

  // R1: lines idle high right out of reset
  a_r1_reset_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (csN == {N{1'b1}} && !leadDone));

  // R2: out-of-range index write leaves the index alone
  a_r2_sel_reject: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_SEL && wrData >= 32'(N)) |=> $stable(selIdx));

  // R3: out-of-range mask write leaves the mask alone
  a_r3_mask_reject: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_MASK && (wrData >> N) != 32'd0) |=> $stable(maskQ));

  // R4: out-of-range mode write leaves the mode alone
  a_r4_mode_reject: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_MODE && wrData > 32'd3) |=> $stable(modeQ));

  // R5: hold mode drives exactly one line off its idle level
  a_r5_hold_one_line: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_HOLD) |-> ($countones(csN ^ maskQ) == 1));

  // R6: modes 1 and 3 leave every line at its idle level
  a_r6_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_OFF || modeQ == MODE_RSVD) |-> (csN == maskQ));

  // R8: a go pulse always follows a request or a half-period tick
  a_r8_go_cause: assert property (@(posedge clk) disable iff (!rstN)
    leadDone |-> $past(frameStart || halfTick));

  // R7: at most one line ever leaves its idle level
  a_r7_single_line: assert property (@(posedge clk) disable iff (!rstN)
    $countones(csN ^ maskQ) <= 1);

endmodule

bind spi_cs_ctrl spi_cs_checker #(.N(N), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .frameStart (frameStart),
  .halfTick   (halfTick),
  .leadDone   (leadDone),
  .csN        (csN),
  .selIdx     (selIdx),
  .maskQ      (maskQ),
  .modeQ      (modeQ)
);

// File: tb/sim_spi_cs_ctrl.sv
`timescale 1ns/1ps
module sim_spi_cs_ctrl;

  localparam int NCS = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           wrEn = 1'b0;
  logic [1:0]     wrAddr = '0;
  logic [31:0]    wrData = '0;
  logic           frameStart = 1'b0;
  logic           frameEnd = 1'b0;
  logic           halfTick = 1'b0;
  logic           leadDone;
  logic [NCS-1:0] csN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side register model
  int unsigned mSel = 0;
  int unsigned mMask = (1 << NCS) - 1;
  int unsigned mMode = 0;

  always #2 clk = ~clk;

  spi_cs_ctrl #(.N(NCS)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameStart(frameStart), .frameEnd(frameEnd), .halfTick(halfTick),
    .leadDone(leadDone), .csN(csN)
  );

  function automatic logic [NCS-1:0] expCs(int unsigned sel, int unsigned mask,
                                           int unsigned mode, bit seqOn);
    logic [NCS-1:0] v;
    bit on;
    v  = mask[NCS-1:0];
    on = (mode == 2) || (mode == 0 && seqOn);
    if (on) v[sel] = ~v[sel];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
    case (a)
      2'd0: if (d < NCS) mSel = d;
      2'd1: if (d < (1 << NCS)) mMask = d;
      2'd2: if (d <= 3) mMode = d;
      default: ;
    endcase
  endtask

  task automatic pulseStart(); frameStart = 1'b1; step(); frameStart = 1'b0; endtask
  task automatic pulseEnd();   frameEnd   = 1'b1; step(); frameEnd   = 1'b0; endtask
  task automatic pulseTick();  halfTick   = 1'b1; step(); halfTick   = 1'b0; endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(); step();
    rstN = 1'b1;
    step();
    // R1 reset state
    check("R1 idle lines", 32'(csN), 32'hF);
    check("R1 go low", 32'(leadDone), 0);

    // R7/R8/R9 default delays (lead 1, trail 1), mode auto, line 0
    pulseStart();
    check("R7 asserted on request", 32'(csN), 32'hE);
    check("R8 no go before tick", 32'(leadDone), 0);
    pulseTick();
    check("R8 go after lead tick", 32'(leadDone), 1);
    step();
    check("R8 go is one cycle", 32'(leadDone), 0);
    pulseEnd();
    check("R9 held through trail", 32'(csN), 32'hE);
    pulseTick();
    check("R9 released after trail", 32'(csN), 32'hF);

    // R8/R9 longer delays: lead 3, trail 2
    wr(2'd3, 32'h0002_0003);
    pulseStart();
    pulseTick(); pulseTick();
    check("R8 lead 3 not yet", 32'(leadDone), 0);
    pulseTick();
    check("R8 lead 3 reached", 32'(leadDone), 1);
    pulseEnd();
    pulseTick();
    check("R9 trail 2 still low", 32'(csN), 32'hE);
    pulseTick();
    check("R9 trail 2 released", 32'(csN), 32'hF);

    // R8/R9 zero delays
    wr(2'd3, 32'h0);
    pulseStart();
    check("R8 lead 0 immediate go", 32'(leadDone), 1);
    check("R7 lead 0 asserted", 32'(csN), 32'hE);
    pulseEnd();
    check("R9 trail 0 immediate release", 32'(csN), 32'hF);

    // R2/R3/R4 range rejection, R5 hold
    wr(2'd0, NCS);
    wr(2'd2, 32'd2);
    check("R2 index N rejected", 32'(csN), 32'hE);
    wr(2'd0, 32'd2);
    check("R2 index 2 accepted", 32'(csN), 32'hB);
    wr(2'd1, 32'h10);
    check("R3 mask 2^N rejected", 32'(csN), 32'hB);
    wr(2'd1, 32'h5);
    check("R5 hold with mask 0101", 32'(csN), 32'h1);
    wr(2'd2, 32'd4);
    check("R4 mode 4 rejected", 32'(csN), 32'h1);
    wr(2'd0, 32'd1);
    check("R5 index change in hold", 32'(csN), 32'h7);
    pulseStart(); pulseEnd();
    check("R5 hold ignores frames", 32'(csN), 32'h7);

    // R6 modes 3 and 1
    wr(2'd2, 32'd3);
    check("R6 off idle", 32'(csN), 32'h5);
    pulseStart();
    check("R6 off ignores request", 32'(csN), 32'h5);
    check("R8 go in off mode", 32'(leadDone), 1);
    pulseEnd();
    wr(2'd2, 32'd1);
    pulseStart();
    check("R6 mode 1 ignores request", 32'(csN), 32'h5);
    pulseEnd();

    // R7 auto with active-high idle line
    wr(2'd0, 32'd0);
    wr(2'd2, 32'd0);
    pulseStart();
    check("R7 inverted idle level", 32'(csN), 32'h4);
    pulseEnd();
    check("R9 back to mask", 32'(csN), 32'h5);

    // random register traffic against the model
    for (int it = 0; it < 300; it++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom % 3);
      case ($urandom % 4)
        0: d = $urandom;
        1: d = $urandom % 8;
        2: d = (a == 2'd0) ? NCS : (a == 2'd1) ? (1 << NCS) : 4;
        default: d = $urandom % 20;
      endcase
      wr(a, d);
      check(a == 2'd0 ? "R2 random index" : a == 2'd1 ? "R3 random mask" : "R4 random mode",
            32'(csN), 32'(expCs(mSel, mMask, mMode, 1'b0)));
      if (mMode == 0) begin
        pulseStart();
        check("R7 random frame", 32'(csN), 32'(expCs(mSel, mMask, mMode, 1'b1)));
        pulseEnd();
        check("R9 random release", 32'(csN), 32'(expCs(mSel, mMask, mMode, 1'b0)));
      end else begin
        check(mMode == 2 ? "R5 random hold" : "R6 random off",
              32'(csN), 32'(expCs(mSel, mMask, mMode, 1'b0)));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule